// File: doc/BRIEF.md
# Cache line ownership arbiter

This block decides which core may modify a cache line when several cores ask for the same line at once. Each core presents one request per cycle. A request names a line, states whether it is a plain store commit or a locked read-modify-write, and carries one store byte. Every line has its own arbitration slot. The slot grants at most one requester per cycle. A granted store updates a small array that holds one data byte per line. The order of grants on a line is therefore the only order in which that line is modified.

Ties between requests that arrive in the same cycle are broken by a rotating priority per line. The search starts at the core after the last winner on that line. A plain store holds the line for its grant cycle only. A locked request keeps the line while the core keeps its hold signal high. A timeout releases the line after a bounded number of cycles. Requests to different lines are granted in the same cycle. The stored byte of any line can be read at any time through a read port.

Top module: `line_owner_arb`

## Requirements
- R1: After a synchronous active-low reset, no grant is issued, every line reads as 0x00, and every line's priority starts at core 0.
- R2: A request to a line that is free is granted in the same cycle. The grant is a one-cycle pulse on that line's grant bit, and the line's grant index holds the requester's core number.
- R3: When several cores request a free line in the same cycle, exactly one is granted. It is the first requester found by searching upward from the core after the previous winner on that line, wrapping from the highest core to core 0.
- R4: A plain store holds the line only for its grant cycle. A requester that lost keeps its request and may be granted on the next cycle.
- R5: A granted locked request holds the line while the winner keeps its hold bit high. The line is given up in the first held cycle where the hold bit is low, and no grant on that line happens in any held cycle. The line can be granted again on the cycle after release.
- R6: A locked hold lasts at most MAX_HOLD (4) cycles after the grant cycle, even if the hold bit stays high.
- R7: Requests from different cores to different lines in the same cycle are all granted in that cycle.
- R8: The winner's byte is written to the line at the clock edge that ends the grant cycle. After two competing stores, the line holds the byte of the store granted second.
- R9: The read port returns the stored byte of the line selected by the read address in the same cycle, with no register on the way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | N_CORES | Request present, one bit per core |
| req_line | input | N_CORES*LINE_AW | Requested line, LINE_AW bits per core, core 0 in the low bits |
| req_locked | input | N_CORES | 1 = locked read-modify-write, 0 = plain store |
| req_data | input | N_CORES*8 | Store byte per core, core 0 in the low bits |
| lock_hold | input | N_CORES | Owner keeps a locked line while its bit is high |
| rd_line | input | LINE_AW | Line to read |
| gnt_valid | output | 2**LINE_AW | Grant pulse, one bit per line |
| gnt_core | output | 2**LINE_AW*log2(N_CORES) | Winning core index per line |
| rd_data | output | 8 | Stored byte of the selected line |

## Verification
Grants are combinational on the request cycle. The bench therefore drives inputs just after the falling edge and compares the grant outputs two nanoseconds before the next rising edge, inside the same cycle. A write becomes visible on the read port one cycle after its grant, and a locked hold is counted from the edge that ends the grant cycle. The behavioural model applies its state updates on each rising edge in the same way, so every comparison is made in the cycle where the result is due. The directed sections cover ties, lock release, the timeout and parallel lines. A random phase then mixes all of them.

// File: rtl/loa_pkg.sv
// Package: shared types for the line ownership arbiter.
// Assumes byte-wide store data.
package loa_pkg;
    localparam int DATA_W = 8;
    typedef logic [DATA_W-1:0] lbyte_t;
endpackage

// File: rtl/loa_pick.sv
// Rotating-priority picker: finds the first set candidate at or after ptr.
// Assumes N is a power of two so index arithmetic wraps naturally.
module loa_pick #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  cand,
    input  logic [IW-1:0] ptr,
    output logic          found,
    output logic [IW-1:0] win
);
    // Scan from the farthest offset down so the nearest candidate is kept.
    always_comb begin
        logic [IW-1:0] idx;
        found = 1'b0;
        win   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            idx = ptr + IW'(k);
            if (cand[idx]) begin
                found = 1'b1;
                win   = idx;
            end
        end
    end
endmodule

// File: rtl/loa_slot.sv
// One line slot: arbitration, lock hold tracking and the line's data byte.
// Assumes requesters keep a request until granted and that only the
// owner's lock_hold bit matters while the line is held.
module loa_slot
    import loa_pkg::*;
#(
    parameter int N        = 4,
    parameter int AW       = 2,
    parameter int LINE_ID  = 0,
    parameter int MAX_HOLD = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1,
    localparam int CW = $clog2(MAX_HOLD) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      req_valid,
    input  logic [N*AW-1:0]   req_line,
    input  logic [N-1:0]      req_locked,
    input  logic [N*DATA_W-1:0] req_data,
    input  logic [N-1:0]      lock_hold,
    output logic              gnt,
    output logic [IW-1:0]     gnt_idx,
    output lbyte_t            line_data
);
    localparam logic [AW-1:0] MY_LINE = AW'(LINE_ID);

    logic [N-1:0]  cand;
    logic          busy;
    logic [IW-1:0] owner;
    logic [CW-1:0] cnt;
    logic [IW-1:0] ptr;
    logic          found;
    lbyte_t        win_data;

    // Candidates: valid requests for this line, none while the line is held.
    always_comb begin
        for (int c = 0; c < N; c++)
            cand[c] = req_valid[c] && (req_line[c*AW +: AW] == MY_LINE) && !busy;
    end

    loa_pick #(.N(N)) u_pick (
        .cand  (cand),
        .ptr   (ptr),
        .found (found),
        .win   (gnt_idx)
    );

    assign gnt      = found;
    assign win_data = req_data[gnt_idx*DATA_W +: DATA_W];

    // Slot state: priority pointer, lock ownership and timeout, data byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            owner     <= '0;
            cnt       <= '0;
            ptr       <= '0;
            line_data <= '0;
        end else if (busy) begin
            if (!lock_hold[owner] || cnt == CW'(MAX_HOLD - 1)) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (found) begin
            line_data <= win_data;
            ptr       <= gnt_idx + 1'b1;
            if (req_locked[gnt_idx]) begin
                busy  <= 1'b1;
                owner <= gnt_idx;
                cnt   <= '0;
            end
        end
    end

    assert_grant_from_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        gnt |-> (req_valid[gnt_idx] && req_line[gnt_idx*AW +: AW] == MY_LINE));

    assert_rotate_after_win_R3: assert property (@(posedge clk) disable iff (!rst_n)
        gnt |=> (ptr == $past(gnt_idx) + 1'b1));

    assert_locked_blocks_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt && req_locked[gnt_idx]) |=> !gnt);

    assert_hold_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt == CW'(MAX_HOLD - 1)) |=> !busy);

    assert_data_written_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gnt |=> (line_data == $past(win_data)));
endmodule

// File: rtl/line_owner_arb.sv
// Top: one arbitration slot per line plus an unregistered read mux.
// Assumes N_CORES is a power of two and at least 2.
module line_owner_arb
    import loa_pkg::*;
#(
    parameter int N_CORES  = 4,
    parameter int LINE_AW  = 2,
    parameter int MAX_HOLD = 4,
    localparam int LINES = 1 << LINE_AW,
    localparam int IW    = $clog2(N_CORES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_CORES-1:0]          req_valid,
    input  logic [N_CORES*LINE_AW-1:0]  req_line,
    input  logic [N_CORES-1:0]          req_locked,
    input  logic [N_CORES*DATA_W-1:0]   req_data,
    input  logic [N_CORES-1:0]          lock_hold,
    input  logic [LINE_AW-1:0]          rd_line,
    output logic [LINES-1:0]            gnt_valid,
    output logic [LINES*IW-1:0]         gnt_core,
    output logic [DATA_W-1:0]           rd_data
);
    lbyte_t line_bytes [LINES];

    // One independent slot per line so different lines grant in parallel.
    for (genvar l = 0; l < LINES; l++) begin : g_slot
        loa_slot #(
            .N        (N_CORES),
            .AW       (LINE_AW),
            .LINE_ID  (l),
            .MAX_HOLD (MAX_HOLD)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_valid  (req_valid),
            .req_line   (req_line),
            .req_locked (req_locked),
            .req_data   (req_data),
            .lock_hold  (lock_hold),
            .gnt        (gnt_valid[l]),
            .gnt_idx    (gnt_core[l*IW +: IW]),
            .line_data  (line_bytes[l])
        );
    end

    // Read port: select the addressed line's byte.
    assign rd_data = line_bytes[rd_line];

    // A core asks for one line at a time, so it never wins two lines at once.
    assert_core_single_win_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid[0] && gnt_valid[1]) |-> (gnt_core[0 +: IW] != gnt_core[IW +: IW]));
endmodule

// File: tb/sim_line_owner_arb.sv
module sim_line_owner_arb;
    localparam int N   = 4;
    localparam int AW  = 2;
    localparam int L   = 4;
    localparam int IW  = 2;
    localparam int MAXH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    bit         v    [N];
    int         ln   [N];
    bit         lk   [N];
    logic [7:0] dt   [N];
    bit         hold [N];
    int         rdl;

    logic [N-1:0]    req_valid, req_locked, lock_hold;
    logic [N*AW-1:0] req_line;
    logic [N*8-1:0]  req_data;
    logic [AW-1:0]   rd_line;
    logic [L-1:0]    gnt_valid;
    logic [L*IW-1:0] gnt_core;
    logic [7:0]      rd_data;

    always_comb begin
        for (int c = 0; c < N; c++) begin
            req_valid[c]        = v[c];
            req_locked[c]       = lk[c];
            lock_hold[c]        = hold[c];
            req_line[c*AW +: AW] = AW'(ln[c]);
            req_data[c*8 +: 8]  = dt[c];
        end
        rd_line = AW'(rdl);
    end

    line_owner_arb u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line(req_line),
        .req_locked(req_locked), .req_data(req_data), .lock_hold(lock_hold),
        .rd_line(rd_line), .gnt_valid(gnt_valid), .gnt_core(gnt_core), .rd_data(rd_data)
    );

    // Reference model state
    bit         m_busy [L];
    int         m_own  [L];
    int         m_cnt  [L];
    int         m_ptr  [L];
    logic [7:0] m_mem  [L];
    int         e_win  [L];

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    task automatic model_reset();
        for (int l = 0; l < L; l++) begin
            m_busy[l] = 0; m_own[l] = 0; m_cnt[l] = 0; m_ptr[l] = 0; m_mem[l] = 8'h00;
        end
    endtask

    task automatic idle();
        for (int c = 0; c < N; c++) begin
            v[c] = 0; ln[c] = 0; lk[c] = 0; dt[c] = 8'h00; hold[c] = 0;
        end
        rdl = 0;
    endtask

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // One cycle: compare before the rising edge, update the model at it,
    // retire granted requests after the falling edge.
    task automatic step();
        #8;
        for (int l = 0; l < L; l++) begin
            e_win[l] = -1;
            if (!m_busy[l]) begin
                for (int k = N - 1; k >= 0; k--) begin
                    int c;
                    c = (m_ptr[l] + k) % N;
                    if (v[c] && ln[c] == l) e_win[l] = c;
                end
            end
            check(gnt_valid[l] == (e_win[l] >= 0), $sformatf("grant line %0d", l),
                  int'(gnt_valid[l]), int'(e_win[l] >= 0));
            if (e_win[l] >= 0)
                check(int'(gnt_core[l*IW +: IW]) == e_win[l], $sformatf("winner line %0d", l),
                      int'(gnt_core[l*IW +: IW]), e_win[l]);
        end
        check(rd_data == m_mem[rdl], "read data", int'(rd_data), int'(m_mem[rdl]));
        @(posedge clk);
        for (int l = 0; l < L; l++) begin
            if (m_busy[l]) begin
                if (!hold[m_own[l]] || m_cnt[l] == MAXH - 1) begin
                    m_busy[l] = 0; m_cnt[l] = 0;
                end else m_cnt[l]++;
            end else if (e_win[l] >= 0) begin
                m_mem[l] = dt[e_win[l]];
                m_ptr[l] = (e_win[l] + 1) % N;
                if (lk[e_win[l]]) begin
                    m_busy[l] = 1; m_own[l] = e_win[l]; m_cnt[l] = 0;
                end
            end
        end
        @(negedge clk);
        for (int l = 0; l < L; l++)
            if (e_win[l] >= 0) v[e_win[l]] = 0;
    endtask

    task automatic req(input int c, input int line, input bit locked, input logic [7:0] d);
        v[c] = 1; ln[c] = line; lk[c] = locked; dt[c] = d;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle();
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R1";
        for (int l = 0; l < L; l++) begin rdl = l; step(); end

        cur_req = "R2";
        req(1, 2, 0, 8'h11);
        step();
        cur_req = "R8"; rdl = 2; step();

        cur_req = "R3";
        req(0, 0, 0, 8'hA0); req(1, 0, 0, 8'hA1); req(2, 0, 0, 8'hA2);
        rdl = 0;
        step();
        cur_req = "R4"; step(); step();
        cur_req = "R8"; step();
        cur_req = "R3";
        req(0, 0, 0, 8'hB0); req(3, 0, 0, 8'hB3);
        step();
        cur_req = "R4"; step();
        cur_req = "R8"; step();

        cur_req = "R5";
        req(2, 1, 1, 8'h52); hold[2] = 1; rdl = 1;
        step();
        req(0, 1, 0, 8'h50);
        step(); step();
        hold[2] = 0;
        step(); step(); step();

        cur_req = "R6";
        req(3, 3, 1, 8'h63); hold[3] = 1; rdl = 3;
        step();
        req(1, 3, 0, 8'h61);
        repeat (6) step();
        hold[3] = 0;
        step();

        cur_req = "R7";
        req(0, 0, 0, 8'h70); req(1, 1, 0, 8'h71); req(2, 2, 0, 8'h72); req(3, 3, 0, 8'h73);
        step();
        cur_req = "R9";
        for (int l = 0; l < L; l++) begin rdl = l; step(); end

        cur_req = "R3";
        for (int i = 0; i < 400; i++) begin
            for (int c = 0; c < N; c++) begin
                if (!v[c] && ($urandom % 3 == 0))
                    req(c, int'($urandom % L), ($urandom % 4 == 0), 8'($urandom));
                hold[c] = ($urandom % 4 != 0);
            end
            rdl = int'($urandom % L);
            step();
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule